// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is a register-mapped port of up to 32 general-purpose I/O lines. A host writes and reads five word-aligned registers over a small request/response channel. Four registers are writable: a static output level, a direction mask, a per-pin blink enable and a per-pin input polarity. The fifth register is read-only and reports the synchronised pin levels after they are XORed with the polarity mask.

The block drives a value and an output enable for every pin. A pin whose direction bit is 1 is an input and its driver is off. A pin whose blink bit is set drives a hardware-toggled square wave instead of its static level. Every blinking pin shares one phase, taken from a free-running divider whose half-period is a parameter.

The request channel follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only one request can be outstanding at a time, so `req_ready` is low while a response is waiting. Each accepted request returns exactly one response on the next cycle. That response holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is high at a clock edge.

Top module: `pio_port`

## Requirements
- R1: After reset, the direction register is all ones, and the level, blink and polarity registers are zero. So `pin_oe` and `pin_out` are all zero, `rsp_valid` is low and `req_ready` is high.
- R2: The direction register is at offset 0x04. A 1 bit makes that pin an input with `pin_oe` low. A 0 bit makes it an output with `pin_oe` high. The change is seen the cycle after the write is accepted.
- R3: The level register is at offset 0x00. Each bit sets `pin_out` for its pin when that pin's blink bit is 0. The change is seen the cycle after the write is accepted.
- R4: The blink register is at offset 0x08. Each pin with a set bit drives a shared phase on `pin_out`. That phase is low after reset and inverts once every `BLINK_HALF` clock cycles.
- R5: The read-only data register is at offset 0x10, and the polarity register is at offset 0x0C. A read of 0x10 returns, per bit, `pin_in` delayed by two flops XORed with the polarity bit. The returned value is the one present at the accepting edge.
- R6: Reads of any offset other than the five listed return zero. Writes to such offsets, or to 0x10, change no register.
- R7: `req_ready` is low while a response is pending. `rsp_valid` rises the cycle after a request is accepted. `rsp_valid` and `rsp_rdata` then stay unchanged until a clock edge where `rsp_ready` is high.
- R8: Reading a writable register returns the last value written to it. A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | WIDTH | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | WIDTH | Read data, zero for writes |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Value driven on each pin |
| pin_oe | output | WIDTH | Driver enable for each pin |

## Verification
The hardest case to reach is a data-register read that is accepted while the pins are changing every cycle, because the returned word depends on exactly two flops of latency. A second hard case is a response held under back-pressure while the pins and the blink phase keep moving. The bench randomises `pin_in` on every cycle. It stalls `rsp_ready` for several cycles on chosen requests, and it turns the blink enable on and off while static levels are set. A reference model that runs in step with the clock checks every output on every cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // Register decode result
  typedef enum logic [2:0] {
    SEL_LEVEL,
    SEL_DIR,
    SEL_BLINK,
    SEL_POL,
    SEL_DIN,
    SEL_NONE
  } pio_sel_e;

  // Byte offsets of the registers
  localparam logic [7:0] OFF_LEVEL = 8'h00;
  localparam logic [7:0] OFF_DIR   = 8'h04;
  localparam logic [7:0] OFF_BLINK = 8'h08;
  localparam logic [7:0] OFF_POL   = 8'h0C;
  localparam logic [7:0] OFF_DIN   = 8'h10;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_in;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pio_blink.sv
module pio_blink #(
  parameter int BLINK_HALF = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CNT_W = $clog2(BLINK_HALF + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase = phase_q;

  // R4: the phase moves only at the end of a half-period
  assert_blink_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(phase_q));
  assert_blink_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/pio_drive.sv
module pio_drive #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] dir_in,
  input  logic [WIDTH-1:0] blink_en,
  input  logic             phase,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_out[i] = blink_en[i] ? phase : level[i];
    assign pin_oe[i]  = ~dir_in[i];
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WIDTH-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WIDTH-1:0]  rsp_rdata,
  input  logic [WIDTH-1:0]  din_sync,
  output logic [WIDTH-1:0]  level_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  blink_q,
  output logic [WIDTH-1:0]  pol_q
);
  pio_sel_e         sel;
  logic             fire;
  logic [WIDTH-1:0] rd_val;
  logic             rsp_valid_q;
  logic [WIDTH-1:0] rsp_rdata_q;

  always_comb begin
    if      (req_addr == ADDR_W'(OFF_LEVEL)) sel = SEL_LEVEL;
    else if (req_addr == ADDR_W'(OFF_DIR))   sel = SEL_DIR;
    else if (req_addr == ADDR_W'(OFF_BLINK)) sel = SEL_BLINK;
    else if (req_addr == ADDR_W'(OFF_POL))   sel = SEL_POL;
    else if (req_addr == ADDR_W'(OFF_DIN))   sel = SEL_DIN;
    else                                     sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_LEVEL: rd_val = level_q;
      SEL_DIR:   rd_val = dir_q;
      SEL_BLINK: rd_val = blink_q;
      SEL_POL:   rd_val = pol_q;
      SEL_DIN:   rd_val = din_sync ^ pol_q;
      default:   rd_val = '0;
    endcase
  end

  assign req_ready = ~rsp_valid_q;
  assign fire      = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
    end else if (fire && req_write) begin
      case (sel)
        SEL_LEVEL: level_q <= req_wdata;
        SEL_DIR:   dir_q   <= req_wdata;
        SEL_BLINK: blink_q <= req_wdata;
        SEL_POL:   pol_q   <= req_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (fire) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R6: writes to data-in or unmapped offsets leave every register alone
  assert_ignore_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && (sel == SEL_NONE || sel == SEL_DIN)) |=>
      ($stable(level_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)));
  // R3: a level write lands on the next cycle
  assert_level_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && sel == SEL_LEVEL) |=> (level_q == $past(req_wdata)));
  // R7: a pending response is held steady under back-pressure
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> (rsp_valid_q && $stable(rsp_rdata_q)));
  // R7: every accepted request yields a response next cycle
  assert_fire_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid_q);
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int ADDR_W     = 5,
  parameter int SYNC_DEPTH = 2,
  parameter int BLINK_HALF = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WIDTH-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WIDTH-1:0]  rsp_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] din_sync;
  logic [WIDTH-1:0] level_q, dir_q, blink_q, pol_q;
  logic             phase;

  pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (din_sync)
  );

  pio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .din_sync  (din_sync),
    .level_q   (level_q),
    .dir_q     (dir_q),
    .blink_q   (blink_q),
    .pol_q     (pol_q)
  );

  pio_blink #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  pio_drive #(.WIDTH(WIDTH)) u_drive (
    .level    (level_q),
    .dir_in   (dir_q),
    .blink_en (blink_q),
    .phase    (phase),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  // R2: a direction write shows on the enables one cycle later
  assert_dir_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == ADDR_W'(OFF_DIR)) |=>
      (pin_oe == ~$past(req_wdata)));
endmodule

// File: tb/pio_port_tb_top.sv
module pio_port_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 32;
  localparam int AW    = 5;
  localparam int HALF  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_wdata = '0, pin_in = '0;
  logic          req_ready, rsp_valid;
  logic [W-1:0]  rsp_rdata, pin_out, pin_oe;

  int checks = 0, errors = 0;
  bit live = 0;
  bit pin_hold = 0;
  logic [W-1:0] pin_fixed = '0;

  pio_port #(.WIDTH(W), .ADDR_W(AW), .BLINK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference model state
  logic [W-1:0] m_level, m_dir, m_blink, m_pol, m_s1, m_s2, m_rdata;
  bit m_rsp_v, m_phase;
  int m_cnt;

  function automatic logic [W-1:0] m_read(input logic [AW-1:0] a);
    case (a)
      5'h00: return m_level;
      5'h04: return m_dir;
      5'h08: return m_blink;
      5'h0C: return m_pol;
      5'h10: return m_s2 ^ m_pol;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = '0; m_dir = '1; m_blink = '0; m_pol = '0;
      m_s1 = '0; m_s2 = '0; m_rdata = '0; m_rsp_v = 0; m_phase = 0; m_cnt = 0;
    end else begin
      if (req_valid && !m_rsp_v) begin
        m_rdata = req_write ? '0 : m_read(req_addr);
        m_rsp_v = 1;
        if (req_write) begin
          case (req_addr)
            5'h00: m_level = req_wdata;
            5'h04: m_dir   = req_wdata;
            5'h08: m_blink = req_wdata;
            5'h0C: m_pol   = req_wdata;
            default: ;
          endcase
        end
      end else if (m_rsp_v && rsp_ready) begin
        m_rsp_v = 0;
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (m_cnt == HALF-1) begin m_cnt = 0; m_phase = !m_phase; end
      else m_cnt++;
    end
    #(CLK_P/4);
    if (live && rst_n) begin
      chk("R7 req_ready", W'(req_ready), W'(!m_rsp_v));
      chk("R7 rsp_valid", W'(rsp_valid), W'(m_rsp_v));
      chk("R5/R6/R8 rsp_rdata", rsp_rdata, m_rdata);
      chk("R2 pin_oe", pin_oe, ~m_dir);
      chk("R3/R4 pin_out", pin_out, (m_blink & {W{m_phase}}) | (~m_blink & m_level));
    end
  end

  always @(negedge clk) pin_in = pin_hold ? pin_fixed : W'($urandom);

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [W-1:0] d,
                      input int stall, output logic [W-1:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R7 held valid", W'(rsp_valid), W'(1));
      chk("R7 busy ready", W'(req_ready), W'(0));
      chk("R7 held data", rsp_rdata, rd);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] rd;
    int toggles;
    logic prev;
    repeat (4) @(negedge clk);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 req_ready", W'(req_ready), W'(1));
    xfer(0, 5'h04, '0, 0, rd); chk("R1 dir reset", rd, 32'hFFFF_FFFF);
    xfer(0, 5'h08, '0, 0, rd); chk("R1 blink reset", rd, '0);
    xfer(0, 5'h0C, '0, 0, rd); chk("R1 pol reset", rd, '0);
    // R2, R3 static drive
    xfer(1, 5'h00, 32'hA5A5_0F0F, 0, rd); chk("R8 write rsp zero", rd, '0);
    xfer(1, 5'h04, 32'h0000_FFFF, 2, rd);
    chk("R2 oe pattern", pin_oe, 32'hFFFF_0000);
    chk("R3 level pattern", pin_out, 32'hA5A5_0F0F);
    xfer(0, 5'h00, '0, 3, rd); chk("R8 level readback", rd, 32'hA5A5_0F0F);
    xfer(0, 5'h04, '0, 0, rd); chk("R8 dir readback", rd, 32'h0000_FFFF);
    // R5 polarity-adjusted input
    xfer(1, 5'h0C, 32'h0000_00FF, 0, rd);
    pin_fixed = 32'h1234_5678; pin_hold = 1;
    repeat (3) @(negedge clk);
    xfer(0, 5'h10, '0, 4, rd); chk("R5 din xor pol", rd, 32'h1234_5687);
    pin_hold = 0;
    for (int n = 0; n < 20; n++) xfer(0, 5'h10, '0, n % 3, rd);
    // R6 ignored writes and unmapped reads
    xfer(1, 5'h10, 32'hFFFF_FFFF, 0, rd);
    xfer(0, 5'h0C, '0, 0, rd); chk("R6 pol after din write", rd, 32'h0000_00FF);
    xfer(1, 5'h02, 32'h1111_1111, 0, rd);
    xfer(1, 5'h14, 32'h2222_2222, 0, rd);
    xfer(0, 5'h00, '0, 0, rd); chk("R6 level unchanged", rd, 32'hA5A5_0F0F);
    chk("R6 pins unchanged", pin_out, 32'hA5A5_0F0F);
    xfer(0, 5'h14, '0, 0, rd); chk("R6 unmapped read", rd, '0);
    xfer(0, 5'h1C, '0, 0, rd); chk("R6 unmapped read hi", rd, '0);
    // R4 blink
    xfer(1, 5'h08, 32'h0000_0003, 0, rd);
    toggles = 0;
    @(posedge clk); #(CLK_P/4); prev = pin_out[0];
    for (int c = 0; c < 4*HALF; c++) begin
      @(posedge clk); #(CLK_P/4);
      if (pin_out[0] != prev) toggles++;
      prev = pin_out[0];
    end
    chk("R4 toggle count", W'(toggles), W'(4));
    chk("R4 shared phase", W'(pin_out[1]), W'(pin_out[0]));
    xfer(1, 5'h08, '0, 1, rd);
    chk("R4 blink off level", pin_out, 32'hA5A5_0F0F);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule